// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte-Lane Writes

This block is a behavioural, synthesizable model of a pipelined synchronous static RAM. Its word is made of four 9-bit byte lanes (eight data bits plus one parity bit per lane). Every synchronous input is captured on the rising clock edge: the address, write data, chip enables, burst controls and write controls. A read places the addressed word in an output register one cycle after capture. A write is carried out one cycle after capture from the registered copies of data and controls.

The word address comes from a built-in burst address generator. Either of two active-low address strobes loads a new start address. An active-low advance input then steps the two low address bits through four words, in linear or interleaved order, and wraps within that group. While no strobe is given and advance is high, the generator keeps accessing the same address. Three chip enables qualify each load. Writes use two levels of control: a global write that forces all four lanes, or a byte-write enable combined with one select per lane. The read data leaves the block on a data bus with a drive-enable. Output enable and a sleep input remove the drive-enable at once, without waiting for a clock.

Depth is a parameter. The default is reduced from a full 64K words so that the model stays cheap to elaborate and simulate.

Top module: `sram_pipe_top`

## Requirements
- R1: After reset, `dataOutEn` is 0 and no access is in flight.
- R2: A read loaded at clock edge k shows the stored word on `dataOut`, with `dataOutEn` high, after edge k+1 (with `oeN` low).
- R3: A load with `gwN` low writes all four lanes, whatever the values of `bweN` and `laneSelN`.
- R4: With `gwN` high, lane i (bits 9i+8 down to 9i of the word) is written only when `bweN` is low and `laneSelN[i]` is low. All other lanes keep their old contents.
- R5: A load counts as an access only if `ce1N`=0, `ce2`=1 and `ce3N`=0 at that edge. Otherwise nothing is written and `dataOutEn` is 0 after the next edge.
- R6: `oeN` high clears `dataOutEn` at once, with no clock edge needed.
- R7: A read loaded in the cycle right after a write to the same address returns the newly written word.
- R8: With `seqLinear`=1, each advance cycle (`advN` low) moves to the next address in the sequence low2 = start_low2 + step (mod 4). The upper address bits stay fixed.
- R9: With `seqLinear`=0, each advance cycle moves to the next address in the sequence low2 = start_low2 XOR step. The upper address bits stay fixed.
- R10: While `sleep` is high, no access is started, `dataOutEn` is 0 and memory contents are kept.
- R11: A write cycle does not drive the bus: `dataOutEn` is 0 after the edge that performs the write.
- R12: In an active burst with no strobe and `advN` high, the same address is accessed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge captures all synchronous inputs |
| rstN | input | 1 | Asynchronous active-low reset of control state |
| addrIn | input | ADDR_W | Start address loaded by a strobe |
| strbCpuN | input | 1 | Active-low address strobe, first source |
| strbCtlN | input | 1 | Active-low address strobe, second source |
| advN | input | 1 | Active-low burst advance |
| seqLinear | input | 1 | 1 = linear burst order, 0 = interleaved |
| ce1N | input | 1 | Active-low chip enable |
| ce2 | input | 1 | Active-high chip enable |
| ce3N | input | 1 | Active-low chip enable |
| gwN | input | 1 | Active-low global write, all lanes |
| bweN | input | 1 | Active-low byte-write enable |
| laneSelN | input | 4 | Active-low per-lane write selects |
| oeN | input | 1 | Active-low output enable, asynchronous |
| sleep | input | 1 | Sleep: blocks access, stops driving the bus |
| dataIn | input | 4*LANE_W | Write data, lane i at bits 9i+8:9i |
| dataOut | output | 4*LANE_W | Registered read data |
| dataOutEn | output | 1 | Bus drive-enable for `dataOut` |

## Verification
The bench builds the block with ADDR_W=6, a 64-word array. With that size, a burst start near a four-word group boundary and the wrap back to the group base are quick to reach, and the whole array is small enough that unrelated words can be checked for being left unchanged. LANE_W stays at 9, so each lane's parity bit is checked on both write paths and on partial-lane merges.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
  localparam int LANES = 4;

  typedef struct packed {
    logic             valid;
    logic             write;
    logic [LANES-1:0] laneWe;
  } stageStrb_t;
endpackage

// File: rtl/sram_burst_addr.sv
module sram_burst_addr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleep,
  input  logic              loadReq,
  input  logic              selNow,
  input  logic              advN,
  input  logic              seqLinear,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] curAddr,
  output logic              accessNow,
  output logic              burstActive
);
  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] baseQ;
  logic [1:0]        offQ;
  logic [1:0]        offNext;
  logic [1:0]        lowBits;
  logic [HI_W-1:0]   hiBits;

  always_comb begin
    offNext = advN ? offQ : 2'(offQ + 2'd1);
    if (seqLinear) lowBits = 2'(baseQ[1:0] + offNext);
    else           lowBits = baseQ[1:0] ^ offNext;
    hiBits = baseQ[ADDR_W-1:2];
    if (sleep) begin
      accessNow = 1'b0;
      curAddr   = addrIn;
    end else if (loadReq) begin
      accessNow = selNow;
      curAddr   = addrIn;
    end else begin
      accessNow = burstActive;
      curAddr   = {hiBits, lowBits};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ       <= '0;
      offQ        <= 2'd0;
      burstActive <= 1'b0;
    end else if (sleep) begin
      burstActive <= 1'b0;
    end else if (loadReq) begin
      burstActive <= selNow;
      baseQ       <= addrIn;
      offQ        <= 2'd0;
    end else if (burstActive) begin
      offQ <= offNext;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strbCpuN,
  input  logic              strbCtlN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  laneSelN,
  input  logic              accessNow,
  input  logic [ADDR_W-1:0] curAddr,
  output logic              loadReq,
  output logic              selNow,
  output stageStrb_t        strb,
  output logic [ADDR_W-1:0] capAddr
);
  logic [LANES-1:0] wrLanes;

  always_comb begin
    loadReq = !strbCpuN || !strbCtlN;
    selNow  = !ce1N && ce2 && !ce3N;
    if (!gwN)       wrLanes = '1;
    else if (!bweN) wrLanes = ~laneSelN;
    else            wrLanes = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strb    <= '0;
      capAddr <= '0;
    end else begin
      strb.valid  <= accessNow;
      strb.write  <= accessNow && (|wrLanes);
      strb.laneWe <= accessNow ? wrLanes : '0;
      if (accessNow) capAddr <= curAddr;
    end
  end
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  stageStrb_t              strb,
  input  logic [ADDR_W-1:0]       capAddr,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] qReg,
  output logic                    qValid
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] dataInQ;

  always_ff @(posedge clk) dataInQ <= dataIn;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (strb.valid && strb.laneWe[g])
        laneMem[capAddr] <= dataInQ[g*LANE_W +: LANE_W];
      if (strb.valid && !strb.write)
        qReg[g*LANE_W +: LANE_W] <= laneMem[capAddr];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) qValid <= 1'b0;
    else       qValid <= strb.valid && !strb.write;
  end
endmodule

// File: rtl/sram_pipe_top.sv
module sram_pipe_top
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic                    strbCpuN,
  input  logic                    strbCtlN,
  input  logic                    advN,
  input  logic                    seqLinear,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    gwN,
  input  logic                    bweN,
  input  logic [LANES-1:0]        laneSelN,
  input  logic                    oeN,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataOutEn
);
  logic              loadReq;
  logic              selNow;
  logic              accessNow;
  logic              burstActive;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] capAddr;
  logic              qValid;
  stageStrb_t        strb;

  sram_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rstN(rstN), .sleep(sleep), .loadReq(loadReq), .selNow(selNow),
    .advN(advN), .seqLinear(seqLinear), .addrIn(addrIn), .curAddr(curAddr),
    .accessNow(accessNow), .burstActive(burstActive)
  );

  sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .strbCpuN(strbCpuN), .strbCtlN(strbCtlN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .gwN(gwN), .bweN(bweN),
    .laneSelN(laneSelN), .accessNow(accessNow), .curAddr(curAddr),
    .loadReq(loadReq), .selNow(selNow), .strb(strb), .capAddr(capAddr)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .capAddr(capAddr),
    .dataIn(dataIn), .qReg(dataOut), .qValid(qValid)
  );

  assign dataOutEn = qValid && !oeN && !sleep;
endmodule

// File: rtl/sram_pipe_chk.sv
module sram_pipe_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sleep,
  input logic              strbCpuN,
  input logic              strbCtlN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic              gwN,
  input logic              advN,
  input logic              seqLinear,
  input logic              burstActive,
  input logic              strbValid,
  input logic              strbWrite,
  input logic [3:0]        strbLanes,
  input logic [ADDR_W-1:0] capAddr,
  input logic              qValid
);
  logic loadIn, selIn;
  assign loadIn = !strbCpuN || !strbCtlN;
  assign selIn  = !ce1N && ce2 && !ce3N;

  AST_DESELECT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && loadIn && !selIn) |=> !strbValid); // R5
  AST_SLEEP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> !strbValid); // R10
  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && loadIn && selIn && !gwN) |=> (strbValid && strbWrite && strbLanes == 4'hF)); // R3
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    (strbValid && !strbWrite) |=> qValid); // R2
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strbValid && strbWrite) |=> !qValid); // R11
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !loadIn && burstActive && advN) |=> $stable(capAddr)); // R12
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !loadIn && burstActive && !advN && seqLinear && $past(seqLinear))
      |=> (capAddr[1:0] == 2'($past(capAddr[1:0]) + 2'd1))); // R8
endmodule

bind sram_pipe_top sram_pipe_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sleep(sleep), .strbCpuN(strbCpuN), .strbCtlN(strbCtlN),
  .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .gwN(gwN), .advN(advN),
  .seqLinear(seqLinear), .burstActive(burstActive), .strbValid(strb.valid),
  .strbWrite(strb.write), .strbLanes(strb.laneWe), .capAddr(capAddr), .qValid(qValid)
);

// File: tb/sram_pipe_top_tb.sv
module sram_pipe_top_tb;
  localparam int AW = 6;
  localparam int LW = 9;
  localparam int DW = 4 * LW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic strbCpuN = 1'b1, strbCtlN = 1'b1, advN = 1'b1, seqLinear = 1'b1;
  logic ce1N = 1'b0, ce2 = 1'b1, ce3N = 1'b0;
  logic gwN = 1'b1, bweN = 1'b1;
  logic [3:0] laneSelN = 4'hF;
  logic oeN = 1'b0, sleep = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic dataOutEn;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sram_pipe_top #(.ADDR_W(AW), .LANE_W(LW)) u_dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .strbCpuN(strbCpuN), .strbCtlN(strbCtlN),
    .advN(advN), .seqLinear(seqLinear), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .gwN(gwN), .bweN(bweN), .laneSelN(laneSelN), .oeN(oeN), .sleep(sleep),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return 36'(a) * 36'h0_0F0F_0F13 + 36'h1_2345_6789;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic setIdle();
    strbCpuN = 1'b1; strbCtlN = 1'b1; advN = 1'b1;
    gwN = 1'b1; bweN = 1'b1; laneSelN = 4'hF;
    ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0;
  endtask

  task automatic endBurst();
    strbCtlN = 1'b0; ce1N = 1'b1;
    @(negedge clk);
    setIdle();
    @(negedge clk);
  endtask

  task automatic doWrite(input int a, input logic [DW-1:0] d, input logic g,
                         input logic b, input logic [3:0] ls);
    addrIn = AW'(a); dataIn = d; strbCtlN = 1'b0; gwN = g; bweN = b; laneSelN = ls;
    @(negedge clk);
    setIdle();
  endtask

  task automatic doRead(input int a, output logic [DW-1:0] d, output logic en);
    addrIn = AW'(a); strbCpuN = 1'b0;
    @(negedge clk);
    setIdle();
    @(negedge clk);
    d = dataOut; en = dataOutEn;
  endtask

  task automatic fillWord(input int a);
    doWrite(a, pat(a), 1'b0, 1'b1, 4'hF);
  endtask

  task automatic testReset();
    chk("R1 reset drive-enable", 36'(dataOutEn), 36'd0);
  endtask

  task automatic testGlobalWrite();
    logic [DW-1:0] d; logic en;
    doWrite(16, pat(16), 1'b0, 1'b0, 4'hF);
    doRead(16, d, en);
    chk("R3 global write all lanes", d, pat(16));
    chk("R2 read drive-enable", 36'(en), 36'd1);
    endBurst();
  endtask

  task automatic testByteWrite();
    logic [DW-1:0] d; logic en; logic [DW-1:0] nw; logic [DW-1:0] exp;
    nw = 36'hA_BCDE_F012;
    doWrite(16, nw, 1'b1, 1'b0, 4'b1010);
    doRead(16, d, en);
    exp = pat(16);
    exp[0 +: LW]  = nw[0 +: LW];
    exp[18 +: LW] = nw[18 +: LW];
    chk("R4 lanes 0 and 2 merged", d, exp);
    endBurst();
    doWrite(16, 36'h0, 1'b1, 1'b1, 4'h0);
    doRead(16, d, en);
    chk("R4 bweN high writes nothing", d, exp);
    endBurst();
  endtask

  task automatic testRawAndWriteQuiet();
    logic [DW-1:0] d; logic en;
    addrIn = AW'(5); dataIn = 36'h5_5AA5_33CC; strbCtlN = 1'b0; gwN = 1'b0;
    @(negedge clk);
    setIdle();
    addrIn = AW'(5); strbCpuN = 1'b0;
    chk("R11 write cycle not driving", 36'(dataOutEn), 36'd0);
    @(negedge clk);
    setIdle();
    @(negedge clk);
    chk("R7 read right after write", dataOut, 36'h5_5AA5_33CC);
    endBurst();
    d = '0; en = 1'b0;
  endtask

  task automatic testChipEnable();
    logic [DW-1:0] d; logic en;
    for (int k = 0; k < 3; k++) begin
      addrIn = AW'(16); dataIn = 36'hF_FFFF_FFFF; strbCtlN = 1'b0; gwN = 1'b0;
      ce1N = (k == 0); ce2 = (k != 1); ce3N = (k == 2);
      @(negedge clk);
      setIdle();
      @(negedge clk);
      chk("R5 deselected not driving", 36'(dataOutEn), 36'd0);
    end
    addrIn = AW'(16); strbCpuN = 1'b0; ce2 = 1'b0;
    @(negedge clk);
    setIdle();
    @(negedge clk);
    chk("R5 deselected read no drive", 36'(dataOutEn), 36'd0);
    doRead(16, d, en);
    chk("R5 deselected writes ignored", d[LW-1:0], 36'hA_BCDE_F012 & 36'h1FF);
    endBurst();
  endtask

  task automatic testOutputEnable();
    logic [DW-1:0] d; logic en;
    doRead(16, d, en);
    oeN = 1'b1;
    #1;
    chk("R6 oeN clears drive at once", 36'(dataOutEn), 36'd0);
    oeN = 1'b0;
    #1;
    chk("R6 oeN low restores drive", 36'(dataOutEn), 36'd1);
    endBurst();
  endtask

  task automatic testBurst(input logic lin, input int start, input string req);
    int ofs;
    addrIn = AW'(start); strbCpuN = 1'b0; seqLinear = lin;
    @(negedge clk);
    setIdle(); advN = 1'b0;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      ofs = lin ? ((start + s) & 3) : ((start & 3) ^ s);
      chk(req, dataOut, pat((start & ~3) | ofs));
    end
    advN = 1'b1;
    endBurst();
    seqLinear = 1'b1;
  endtask

  task automatic testHold();
    addrIn = AW'(34); strbCpuN = 1'b0;
    @(negedge clk);
    setIdle();
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk("R12 hold repeats address", dataOut, pat(34));
    end
    endBurst();
  endtask

  task automatic testSleep();
    logic [DW-1:0] d; logic en;
    addrIn = AW'(33); strbCpuN = 1'b0;
    @(negedge clk);
    setIdle();
    @(negedge clk);
    sleep = 1'b1;
    #1;
    chk("R10 sleep clears drive", 36'(dataOutEn), 36'd0);
    doWrite(33, 36'h0, 1'b0, 1'b1, 4'hF);
    @(negedge clk);
    chk("R10 no drive during sleep", 36'(dataOutEn), 36'd0);
    sleep = 1'b0;
    @(negedge clk);
    doRead(33, d, en);
    chk("R10 contents kept", d, pat(33));
    endBurst();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    setIdle();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGlobalWrite();
    testByteWrite();
    testRawAndWriteQuiet();
    testChipEnable();
    testOutputEnable();
    for (int a = 32; a < 36; a++) fillWord(a);
    endBurst();
    testBurst(1'b1, 33, "R8 linear burst");
    testBurst(1'b0, 33, "R9 interleaved burst");
    testBurst(1'b0, 34, "R9 interleaved burst from 2");
    testHold();
    testSleep();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule